// File: doc/BRIEF.md
# DLL Lock Sampler with Clock Gating

This block collects the lock result of two DLLs. Their status words cannot be trusted while the memory clock of the DLL's own PHY is running. After a start pulse it works on PHY 0 first and then on PHY 1. For each PHY it opens a one-cycle window in which that PHY's bit of the clock-gate control word is cleared. During that window it captures the status word. In the next cycle it puts the gate word back to its original value.

A captured word counts as locked only when its three lowest bits are all set. If the word is not locked, the block waits a fixed number of cycles and opens another window. Once a PHY is locked, the 7-bit coarse lock field of that same captured word is presented on the PHY's own output. An attempt limit stops a DLL that never locks from hanging the sequence.

The caller supplies the current gate word on `gate_base`. The block's `gate_word` output replaces it on the way to the clock gating cells.

Top module: `dll_lock_sampler`

## Requirements
- R1: After reset, `done` and `timeout` are 0, both coarse outputs are 0, and `gate_word` equals `gate_base`.
- R2: While PHY 0 is sampled, only bit 0 of `gate_word` is cleared. While PHY 1 is sampled, only bit 1 is cleared. Every other bit always equals `gate_base`, and bits 0 and 1 are never cleared together.
- R3: Each sampling window lasts exactly one clock cycle. In the cycle after it, `gate_word` equals `gate_base` again, whatever value was captured.
- R4: A captured status is locked only when status[2:0] equals 3'b111. A partial value such as 3'b011 or 3'b110 counts as not locked and leads to a retry.
- R5: Two consecutive windows for the same PHY begin exactly WAIT_CYC+2 cycles apart. With the default WAIT_CYC=10 that is 12 cycles.
- R6: No PHY 1 window occurs until PHY 0 has locked. The first PHY 1 window comes two cycles after the PHY 0 window that locked.
- R7: Each coarse output equals status[16:10] of the window sample that showed lock. A status value presented outside a window is never used.
- R8: `done` rises when the sequence ends and stays high until the next accepted `start`. A `start` that arrives while a sequence is running is ignored.
- R9: A PHY that has not locked after MAX_TRIES windows (default 8) ends the sequence with `done` and `timeout` both high. No PHY after it is sampled. A PHY that did not lock in this run reads 0 on its coarse output, because an accepted `start` clears the coarse outputs, `done` and `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a sequence when idle or finished |
| gate_base | input | 32 | Current clock-gate control word |
| gate_word | output | 32 | Gate word driven to the gating cells |
| phy0_status | input | 32 | Lock status word of PHY 0 |
| phy1_status | input | 32 | Lock status word of PHY 1 |
| done | output | 1 | Sequence finished; held until the next start |
| timeout | output | 1 | A PHY failed to lock within MAX_TRIES windows |
| phy0_coarse | output | 7 | Coarse lock value of PHY 0 |
| phy1_coarse | output | 7 | Coarse lock value of PHY 1 |

## Verification
The hardest case to reach from the ports is a status input that looks locked, but with a wrong coarse field, in every cycle except the gated window. Such a value only exposes a design that samples in the wrong cycle. The bench models each PHY as a function of its gate bit. It counts the windows that PHY has seen, returns the real answer only while its gate bit is cleared, and returns a decoy value at all other times. The same model brings lock on a chosen attempt, never brings lock at all, or shows a partial lock pattern. This is how the retry spacing, the ordering between the PHYs and both timeout paths are reached.

// File: rtl/dls_pkg.sv
// Shared definitions for the DLL lock sampler.
// Assumes the status layout: fine lock in [2:0], coarse lock in [16:10].
package dls_pkg;
    localparam int FINE_W     = 3;
    localparam int COARSE_LSB = 10;
    localparam int COARSE_W   = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GATE,
        S_EVAL,
        S_WAIT,
        S_DONE
    } dls_state_t;
endpackage

// File: rtl/dls_gate_ctrl.sv
// Builds the gate word: clears the selected PHY's gate bit while a window is
// open and passes the base word through unchanged otherwise.
// Assumes PHY n owns gate bit n and that NUM_PHY <= GATE_W.
module dls_gate_ctrl #(
    parameter int GATE_W  = 32,
    parameter int NUM_PHY = 2,
    localparam int SEL_W  = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
    input  logic [GATE_W-1:0] base_i,
    input  logic              window_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [GATE_W-1:0] word_o
);
    logic [GATE_W-1:0] clr_mask;

    // One-hot mask of the bit that belongs to the selected PHY.
    always_comb begin
        clr_mask = '0;
        for (int i = 0; i < NUM_PHY; i++) begin
            if (window_i && (sel_i == SEL_W'(i))) clr_mask[i] = 1'b1;
        end
    end

    // Gate word seen by the clock gating cells.
    assign word_o = base_i & ~clr_mask;
endmodule

// File: rtl/dls_sampler.sv
// Captures one status word at the end of a gated window and decodes the
// fine-lock flag and the coarse field from that single captured word.
// Assumes capture_i is high only in the cycle in which the clock is gated.
module dls_sampler
    import dls_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture_i,
    input  logic [STAT_W-1:0]   stat_i,
    output logic                locked_o,
    output logic [COARSE_W-1:0] coarse_o
);
    logic [STAT_W-1:0] stat_q;

    // Hold the word sampled during the window.
    always_ff @(posedge clk) begin
        if (!rst_n)         stat_q <= '0;
        else if (capture_i) stat_q <= stat_i;
    end

    // Decode both fields from the same captured sample.
    assign locked_o = &stat_q[FINE_W-1:0];
    assign coarse_o = stat_q[COARSE_LSB +: COARSE_W];
endmodule

// File: rtl/dls_wait_timer.sv
// Down-counter for the pause between retries. After load_i it reports
// expired_o WAIT_CYC cycles later. Assumes WAIT_CYC >= 1.
module dls_wait_timer #(
    parameter int WAIT_CYC = 10,
    localparam int CNT_W   = $clog2(WAIT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on a failed sample, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= CNT_W'(WAIT_CYC - 1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WAIT_CYC - 1));
    assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dll_lock_sampler.sv
// Top level: steps through the PHYs in order. For each PHY it opens a
// one-cycle gated window, captures the status, restores the gate word and
// tests for fine lock. It retries after a pause and gives up after MAX_TRIES
// windows. Assumes gate_base is stable while a sequence runs.
module dll_lock_sampler
    import dls_pkg::*;
#(
    parameter int GATE_W    = 32,
    parameter int STAT_W    = 32,
    parameter int WAIT_CYC  = 10,
    parameter int MAX_TRIES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [GATE_W-1:0]   gate_base,
    output logic [GATE_W-1:0]   gate_word,
    input  logic [STAT_W-1:0]   phy0_status,
    input  logic [STAT_W-1:0]   phy1_status,
    output logic                done,
    output logic                timeout,
    output logic [COARSE_W-1:0] phy0_coarse,
    output logic [COARSE_W-1:0] phy1_coarse
);
    localparam int NUM_PHY = 2;
    localparam int SEL_W   = 1;
    localparam int TRY_W   = $clog2(MAX_TRIES + 1);

    dls_state_t          state_q;
    logic [SEL_W-1:0]    phy_q;
    logic [TRY_W-1:0]    tries_q;
    logic                done_q, timeout_q;
    logic                window, accept, locked, expired, last_phy, give_up;
    logic [COARSE_W-1:0] coarse_smp;
    logic [STAT_W-1:0]   stat_sel;
    logic [STAT_W-1:0]   stat_arr [NUM_PHY];
    logic [COARSE_W-1:0] coarse_q [NUM_PHY];

    assign stat_arr[0] = phy0_status;
    assign stat_arr[1] = phy1_status;

    assign window   = (state_q == S_GATE);
    assign accept   = start && (state_q == S_IDLE || state_q == S_DONE);
    assign last_phy = (phy_q == SEL_W'(NUM_PHY - 1));
    assign give_up  = (tries_q == TRY_W'(MAX_TRIES - 1));
    assign stat_sel = stat_arr[phy_q];

    dls_gate_ctrl #(.GATE_W(GATE_W), .NUM_PHY(NUM_PHY)) u_gate (
        .base_i   (gate_base),
        .window_i (window),
        .sel_i    (phy_q),
        .word_o   (gate_word)
    );

    dls_sampler #(.STAT_W(STAT_W)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (window),
        .stat_i    (stat_sel),
        .locked_o  (locked),
        .coarse_o  (coarse_smp)
    );

    dls_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (state_q == S_EVAL && !locked),
        .expired_o (expired)
    );

    // Sequence control: gate, evaluate, pause, advance or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            phy_q     <= '0;
            tries_q   <= '0;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE, S_DONE: begin
                    if (accept) begin
                        state_q   <= S_GATE;
                        phy_q     <= '0;
                        tries_q   <= '0;
                        done_q    <= 1'b0;
                        timeout_q <= 1'b0;
                    end
                end
                S_GATE: state_q <= S_EVAL;
                S_EVAL: begin
                    if (locked) begin
                        tries_q <= '0;
                        if (last_phy) begin
                            state_q <= S_DONE;
                            done_q  <= 1'b1;
                        end else begin
                            phy_q   <= phy_q + 1'b1;
                            state_q <= S_GATE;
                        end
                    end else if (give_up) begin
                        state_q   <= S_DONE;
                        done_q    <= 1'b1;
                        timeout_q <= 1'b1;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: if (expired) state_q <= S_GATE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Per-PHY coarse registers, cleared on start and loaded on lock.
    for (genvar g = 0; g < NUM_PHY; g++) begin : g_coarse
        always_ff @(posedge clk) begin
            if (!rst_n || accept)
                coarse_q[g] <= '0;
            else if (state_q == S_EVAL && locked && phy_q == SEL_W'(g))
                coarse_q[g] <= coarse_smp;
        end
    end

    assign done        = done_q;
    assign timeout     = timeout_q;
    assign phy0_coarse = coarse_q[0];
    assign phy1_coarse = coarse_q[1];

    assert_gate_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_word ^ gate_base) & ~GATE_W'(3)) == '0 &&
        $countones(gate_word ^ gate_base) <= 1);
    assert_one_cycle_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_word != gate_base) |=> (gate_word == gate_base));
    assert_phy_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_q < $past(phy_q)) |-> $past(start));
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    assert_timeout_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);
endmodule

// File: tb/tb_dll_lock_sampler.sv
module tb_dll_lock_sampler;
    localparam int W_CYC = 10;
    localparam int MAXT  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] gate_base = 32'hA5C3_0F7F;
    logic [31:0] gate_word, st0, st1;
    logic        done, timeout;
    logic [6:0]  co0, co1;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dll_lock_sampler #(.WAIT_CYC(W_CYC), .MAX_TRIES(MAXT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gate_base(gate_base),
        .gate_word(gate_word), .phy0_status(st0), .phy1_status(st1),
        .done(done), .timeout(timeout), .phy0_coarse(co0), .phy1_coarse(co1)
    );

    // PHY model settings, written only by the tasks
    logic [6:0] m_c0, m_c1;
    logic [2:0] m_nl0, m_nl1;
    int         m_need0, m_need1;
    int         snap0, snap1;
    int         mark = 1;

    // Window counters per PHY, advanced at the sampling edge
    int win0 = 0, win1 = 0;
    always @(posedge clk) begin
        if (!gate_word[0]) win0 <= win0 + 1;
        if (!gate_word[1]) win1 <= win1 + 1;
    end

    function automatic logic [31:0] mk(input logic [6:0] c, input logic [2:0] f);
        return {15'h5A5A, c, 7'h2B, f};
    endfunction

    // Status model: real answer only while the gate bit is cleared, decoy otherwise
    always_comb begin
        if (gate_word[0]) st0 = mk(~m_c0, 3'b111);
        else st0 = (m_need0 > 0 && (win0 - snap0 + 1) >= m_need0) ? mk(m_c0, 3'b111)
                                                                  : mk(m_c0 ^ 7'h11, m_nl0);
        if (gate_word[1]) st1 = mk(~m_c1, 3'b111);
        else st1 = (m_need1 > 0 && (win1 - snap1 + 1) >= m_need1) ? mk(m_c1, 3'b111)
                                                                  : mk(m_c1 ^ 7'h11, m_nl1);
    end

    // Gate-word monitor, sampled away from the active edge
    int cyc = 0;
    int bit_err = 0, consec_err = 0, gap_err = 0;
    int last_w0 = 0, last_w1 = 0, first_w1 = 0;
    logic prev_low = 1'b0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if ((((gate_word ^ gate_base) & ~32'h3) != 0) || (!gate_word[0] && !gate_word[1]))
                bit_err <= bit_err + 1;
            if (gate_word != gate_base && prev_low) consec_err <= consec_err + 1;
            prev_low <= (gate_word != gate_base);
            if (!gate_word[0]) begin
                if (last_w0 >= mark && cyc - last_w0 != W_CYC + 2) gap_err <= gap_err + 1;
                last_w0 <= cyc;
            end
            if (!gate_word[1]) begin
                if (last_w1 >= mark && cyc - last_w1 != W_CYC + 2) gap_err <= gap_err + 1;
                if (first_w1 < mark) first_w1 <= cyc;
                last_w1 <= cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One complete sequence followed by checks on all outcomes
    task automatic run_seq(input logic [6:0] c0, input logic [6:0] c1,
                           input int need0, input int need1,
                           input logic [2:0] nl0, input logic [2:0] nl1,
                           input bit busy_start);
        bit to0, to1;
        int e_w0, e_w1, be, ce, ge;
        @(negedge clk);
        m_c0 = c0; m_c1 = c1; m_need0 = need0; m_need1 = need1;
        m_nl0 = nl0; m_nl1 = nl1;
        snap0 = win0; snap1 = win1;
        mark = cyc + 1;
        be = bit_err; ce = consec_err; ge = gap_err;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8 done cleared by start", done, 0);
        if (busy_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
        to0 = (need0 == 0 || need0 > MAXT);
        to1 = !to0 && (need1 == 0 || need1 > MAXT);
        e_w0 = to0 ? MAXT : need0;
        e_w1 = to0 ? 0 : (to1 ? MAXT : need1);
        chk(done == 1'b1, "R8 done raised", done, 1);
        chk(timeout == (to0 || to1), "R9 timeout flag", timeout, to0 || to1);
        chk(win0 - snap0 == e_w0, "R4/R9 phy0 window count", win0 - snap0, e_w0);
        chk(win1 - snap1 == e_w1, "R4/R9 phy1 window count", win1 - snap1, e_w1);
        chk(co0 == (to0 ? 7'h0 : c0), "R7 phy0 coarse", co0, to0 ? 0 : c0);
        chk(co1 == ((to0 || to1) ? 7'h0 : c1), "R7 phy1 coarse", co1, (to0 || to1) ? 0 : c1);
        chk(bit_err == be, "R2 gate bits", bit_err - be, 0);
        chk(consec_err == ce, "R3 single-cycle window", consec_err - ce, 0);
        chk(gap_err == ge, "R5 retry spacing", gap_err - ge, 0);
        if (!to0) chk(first_w1 == last_w0 + 2, "R6 phy1 after phy0 lock", first_w1, last_w0 + 2);
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R8 done held", done, 1);
        chk(gate_word == gate_base, "R3 gate restored when idle", gate_word, gate_base);
    endtask

    task automatic t_reset();
        chk(done == 1'b0, "R1 done at reset", done, 0);
        chk(timeout == 1'b0, "R1 timeout at reset", timeout, 0);
        chk(co0 == 7'h0 && co1 == 7'h0, "R1 coarse at reset", {co1, co0}, 0);
        chk(gate_word == gate_base, "R1 gate word at reset", gate_word, gate_base);
    endtask

    task automatic t_first_try();     run_seq(7'h2A, 7'h51, 1, 1, 3'b000, 3'b000, 0); endtask
    task automatic t_retries();       run_seq(7'h13, 7'h64, 3, 2, 3'b011, 3'b110, 0); endtask
    task automatic t_field_edges();   run_seq(7'h7F, 7'h00, 1, 2, 3'b101, 3'b011, 0); endtask
    task automatic t_timeout_phy1();  run_seq(7'h3C, 7'h55, 1, 0, 3'b000, 3'b110, 0); endtask
    task automatic t_timeout_phy0();  run_seq(7'h0F, 7'h70, 0, 1, 3'b011, 3'b000, 0); endtask
    task automatic t_busy_start();    run_seq(7'h21, 7'h42, 2, 1, 3'b110, 3'b000, 1); endtask
    task automatic t_last_try();      run_seq(7'h08, 7'h19, MAXT, 1, 3'b011, 3'b000, 0); endtask

    initial begin
        m_c0 = 0; m_c1 = 0; m_need0 = 1; m_need1 = 1; m_nl0 = 0; m_nl1 = 0;
        snap0 = 0; snap1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_try();
        t_retries();
        t_field_edges();
        t_timeout_phy1();
        t_first_try();
        t_timeout_phy0();
        t_busy_start();
        t_last_try();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule